// File: doc/BRIEF.md
# Prescaled Watchdog Timer

A watchdog peripheral sitting on a simple single-cycle register bus. The input clock is divided in two stages: a programmable prescaler divides by a value from 1 to 256, and a selectable fixed divider then divides by 16, 32, 64 or 128. Each resulting tick decrements a 16-bit down-counter. When a tick finds the counter at zero, the timer has expired. The counter reloads from the reload register and keeps counting. On expiry the block pulses an interrupt and/or latches a reset request, depending on which of the two is enabled.

Software keeps the system alive by writing the count register before expiry. It stops the timer by clearing the enable bit. Because the counter reloads on each expiry, an interrupt-only setup works as a periodic timer.

Top module: `wdt_top`

## Requirements
- R1: After rst_ni is released, the control register reads 0x00008021, the reload and count registers read 0x00008000, and irq_o and rst_req_o are 0.
- R2: Registers sit at byte offsets 0x0 (control), 0x4 (reload) and 0x8 (count). In the control register only bits [15:8], 5, [4:3], 2 and 0 are stored; all other bits read 0. The reload and count registers hold 16 bits, and their upper bits read 0. Any other offset reads 0.
- R3: The control fields are: bit 0 reset enable, bit 2 interrupt enable, bit 5 timer enable, bits [4:3] divider select S, and bits [15:8] prescale P. While enabled, a tick occurs every (P+1)*(16<<S) clock cycles. Both divider stages are held clear while the timer is disabled, so the first tick comes one full period after the timer is enabled.
- R4: Each tick decrements a nonzero count by 1. A tick that finds the count at 0 is an expiry, and the count is reloaded from the reload register. A count of N therefore expires on tick N+1, and the timer then repeats with period (reload+1) ticks.
- R5: When interrupt enable is set at expiry, irq_o is high for exactly one cycle, in the cycle after the expiring tick.
- R6: When reset enable is set at expiry, rst_req_o rises and stays high until rst_ni is asserted. When reset enable is clear, rst_req_o stays low.
- R7: A write to the count register loads the live counter on that clock edge, and it takes priority over a tick in the same cycle. Writing the count register regularly keeps the timer from expiring.
- R8: While the timer is disabled, the count holds its value and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high together with req_i |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | One-cycle expiry interrupt |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
The hardest case to reach is an exact expiry time: the cycle of expiry depends on both divider stages and the count all at once, and it only becomes visible several thousand cycles after the enable. The bench therefore sweeps every divider select together with several prescale values and small counts. It measures the number of edges from the enabling write to each interrupt and compares that number with (N+1)(P+1)(16<<S). A second measurement covers the reload-driven repeat period. The reset request is checked by running an expiry with only reset enable set, and then applying an external reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned PRE_W    = 8;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned BASE_LOG = 4;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_RELD = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 4'h8;

  localparam int unsigned B_RST_EN = 0;
  localparam int unsigned B_IRQ_EN = 2;
  localparam int unsigned B_SEL_LO = 3;
  localparam int unsigned B_EN     = 5;
  localparam int unsigned B_PRE_LO = 8;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             en;
    logic [SEL_W-1:0] sel;
    logic             irq_en;
    logic             rst_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{pre: 8'h80, en: 1'b1, sel: 2'd0, irq_en: 1'b0, rst_en: 1'b1};
  localparam logic [CNT_W-1:0] CNT_RST = 16'h8000;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reld_o,
  output logic              cnt_we_o,
  output logic [CNT_W-1:0]  cnt_wval_o
);
  logic wr;
  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= CTRL_RST;
      reld_o <= CNT_RST;
    end else if (wr) begin
      if (addr_i == OFF_CTRL) begin
        ctrl_o.pre    <= wdata_i[B_PRE_LO +: PRE_W];
        ctrl_o.en     <= wdata_i[B_EN];
        ctrl_o.sel    <= wdata_i[B_SEL_LO +: SEL_W];
        ctrl_o.irq_en <= wdata_i[B_IRQ_EN];
        ctrl_o.rst_en <= wdata_i[B_RST_EN];
      end
      if (addr_i == OFF_RELD) reld_o <= wdata_i[CNT_W-1:0];
    end
  end

  assign cnt_we_o   = wr && (addr_i == OFF_CNT);
  assign cnt_wval_o = wdata_i[CNT_W-1:0];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_CTRL: begin
        rdata_o[B_PRE_LO +: PRE_W] = ctrl_o.pre;
        rdata_o[B_EN]              = ctrl_o.en;
        rdata_o[B_SEL_LO +: SEL_W] = ctrl_o.sel;
        rdata_o[B_IRQ_EN]          = ctrl_o.irq_en;
        rdata_o[B_RST_EN]          = ctrl_o.rst_en;
      end
      OFF_RELD: rdata_o[CNT_W-1:0] = reld_o;
      OFF_CNT:  rdata_o[CNT_W-1:0] = cnt_i;
      default:  rdata_o = '0;
    endcase
  end

  // R2: a control write is visible on the next cycle
  a_r2_ctrl_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_CTRL) |=> (ctrl_o.en == $past(wdata_i[B_EN])));
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen
  import wdt_pkg::*;
#(
  parameter int unsigned P_W  = PRE_W,
  parameter int unsigned S_W  = SEL_W,
  parameter int unsigned BASE = BASE_LOG
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [P_W-1:0] pre_i,
  input  logic [S_W-1:0] sel_i,
  output logic           tick_o
);
  localparam int unsigned DIV_W = BASE + (1 << S_W) - 1;

  logic [P_W-1:0]   pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_max;
  logic             pre_tick;

  assign div_max  = DIV_W'((1 << (BASE + 32'(sel_i))) - 1);
  assign pre_tick = en_i && (pre_cnt == pre_i);
  assign tick_o   = pre_tick && (div_cnt == div_max);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (!en_i) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else begin
      pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
      if (pre_tick) div_cnt <= tick_o ? '0 : div_cnt + 1'b1;
    end
  end

  a_r3_tick_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> en_i);
  a_r3_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pre_cnt == '0 && div_cnt == '0));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         we_i,
  input  logic [W-1:0] wval_i,
  input  logic [W-1:0] reld_i,
  input  logic         irq_en_i,
  input  logic         rst_en_i,
  output logic [W-1:0] cnt_o,
  output logic         irq_o,
  output logic         rst_req_o
);
  logic expire;
  assign expire = tick_i && !we_i && (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= W'(CNT_RST);
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      irq_o <= expire && irq_en_i;
      if (expire && rst_en_i) rst_req_o <= 1'b1;
      if (we_i)         cnt_o <= wval_i;
      else if (expire)  cnt_o <= reld_i;
      else if (tick_i)  cnt_o <= cnt_o - 1'b1;
    end
  end

  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !we_i && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - 1'b1));
  a_r5_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r6_rst_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);
  a_r6_rst_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(rst_en_i));
  a_r7_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cnt_o == $past(wval_i)));
  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !we_i) |=> $stable(cnt_o));
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reld, cnt, cnt_wval;
  logic             cnt_we, tick;

  wdt_regs u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .rdata_o, .ctrl_o(ctrl), .reld_o(reld),
    .cnt_we_o(cnt_we), .cnt_wval_o(cnt_wval)
  );

  wdt_tick_gen #(.P_W(PRE_W), .S_W(SEL_W), .BASE(BASE_LOG)) u_tick (
    .clk_i, .rst_ni, .en_i(ctrl.en), .pre_i(ctrl.pre), .sel_i(ctrl.sel), .tick_o(tick)
  );

  wdt_counter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .we_i(cnt_we), .wval_i(cnt_wval),
    .reld_i(reld), .irq_en_i(ctrl.irq_en), .rst_en_i(ctrl.rst_en),
    .cnt_o(cnt), .irq_o, .rst_req_o
  );
endmodule

// File: tb/wdt_top_tb_top.sv
`timescale 1ns/1ps
module wdt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_req;
  int checks = 0, fails = 0;
  longint cycles = 0;

  always #4 clk = ~clk;

  wdt_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] ctl(int p, int s, bit en, bit ie, bit re);
    return (32'(p) << 8) | (32'(en) << 5) | (32'(s) << 3) | (32'(ie) << 2) | 32'(re);
  endfunction

  // Count edges until irq is seen (sampled at negedge); limit guards hangs.
  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (!irq && n < 5000);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog timeout actual=%0d expected<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd(4'h0, v); check("R1 ctrl", v, 32'h8021);
    rd(4'h4, v); check("R1 reload", v, 32'h8000);
    rd(4'h8, v); check("R1 count", v, 32'h8000);
    check("R1 irq", irq, 0);
    check("R1 rst_req", rst_req, 0);
    wr(4'h0, 32'h0);

    // R2 field masks and unmapped offset
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, v); check("R2 ctrl mask", v, 32'h0000_FF3D);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'hFFFF_1234); rd(4'h4, v); check("R2 reload mask", v, 32'h1234);
    wr(4'h8, 32'hABCD_0042); rd(4'h8, v); check("R2 count mask", v, 32'h42);
    rd(4'hC, v); check("R2 unmapped", v, 0);

    // R3 R4 R5: sweep divider select, prescale and count
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < 2; k++) begin
          automatic int cn = k * 2;
          automatic int per = (cn + 1) * (p + 1) * (16 << s);
          wr(4'h0, 32'h0);
          wr(4'h4, 32'(cn));
          wr(4'h8, 32'(cn));
          wr(4'h0, ctl(p, s, 1, 1, 0));
          wait_irq(n);
          check($sformatf("R3 R4 first expiry p=%0d s=%0d n=%0d", p, s, cn), n, per);
          @(posedge clk); @(negedge clk);
          check("R5 irq one cycle", irq, 0);
          wait_irq(n);
          check($sformatf("R4 R5 repeat period p=%0d s=%0d n=%0d", p, s, cn), n + 1, per);
          check("R6 no rst_req without enable", rst_req, 0);
        end
    wr(4'h0, 32'h0);

    // R4 live count decrements once per tick
    wr(4'h8, 32'd5);
    wr(4'h0, ctl(0, 0, 1, 1, 0));
    repeat (40) @(posedge clk);
    rd(4'h8, v); check("R4 live count after 2 ticks", v, 3);
    wr(4'h0, 32'h0);

    // R7 keep-alive writes prevent expiry
    wr(4'h4, 32'd2); wr(4'h8, 32'd2);
    wr(4'h0, ctl(0, 0, 1, 1, 1));
    seen = 0;
    for (int i = 0; i < 15; i++) begin
      for (int j = 0; j < 18; j++) begin @(negedge clk); if (irq) seen = 1; end
      wr(4'h8, 32'd2);
    end
    check("R7 keep-alive no irq", seen, 0);
    check("R7 keep-alive no rst_req", rst_req, 0);

    // R8 disable freezes count
    wr(4'h8, 32'd9);
    repeat (20) @(posedge clk);
    wr(4'h0, ctl(0, 0, 0, 1, 1));
    rd(4'h8, v);
    seen = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (irq) seen = 1; end
    rd(4'h8, v2);
    check("R8 count frozen", v2, v);
    check("R8 no irq while disabled", seen, 0);

    // R6 reset request, sticky until rst_ni
    wr(4'h8, 32'd0);
    wr(4'h0, ctl(0, 0, 1, 0, 1));
    repeat (17) @(posedge clk);
    @(negedge clk);
    check("R6 rst_req set", rst_req, 1);
    check("R5 no irq when disabled", irq, 0);
    wr(4'h0, 32'h0);
    repeat (10) @(negedge clk);
    check("R6 rst_req held", rst_req, 1);
    rst_n = 1'b0;
    #1 check("R6 rst_req cleared by reset", rst_req, 0);
    @(negedge clk); rst_n = 1'b1;
    rd(4'h0, v); check("R1 ctrl after reset", v, 32'h8021);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule